// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block turns a master audio clock into the two timing signals that a serial audio port needs when it is the clock master: a bit clock and a frame clock. The frame clock is either a two-phase word select for I2S or a one-bit-wide sync pulse for TDM. Two small configuration fields set the timing. A half-ratio code gives the number of master clock cycles in each half of a bit clock period. A frame code gives the frame length in units of 32 bit clocks, and code 0 stands for the longest frame of 512 bit clocks.

Every master clock cycle is a tick of the block's `clk`. A new configuration is adopted only at a frame boundary, so a frame that has started always runs to its end with the settings it started with. When the port is a clock slave, the outputs fall quiet, the output-enable drops and the counters freeze. If a code is not supported, an error flag is raised and the clocks stop. They start again as soon as valid codes return.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is high and on the first clock after it, `bclk_o`, `fclk_o`, `clk_oe` and `cfg_err` are all 0.
- R2: With half-ratio code H (1 to 7), the bit clock period is 2·H master cycles, of which `bclk_o` is high for H cycles.
- R3: Frame code C of 1, 2, 4 or 8 sets a frame of 32·C bit clocks, and code 0 sets 512 bit clocks. The `fclk_o` period is therefore 2·H·(frame bits) master cycles.
- R4: With `tdm_mode`=0 (I2S), `fclk_o` is low for the first half of each frame and high for the second half. It is high for H·(frame bits) master cycles.
- R5: With `tdm_mode`=1, `fclk_o` is high for exactly one bit clock (2·H master cycles) at the start of each frame.
- R6: A change of half-ratio code, frame code or `tdm_mode` takes effect at the next frame boundary. The frame in progress completes with its old length.
- R7: A half-ratio code of 0 or above 7, or a frame code other than 0, 1, 2, 4 or 8, sets `cfg_err` to 1 and stops the clocks, with `clk_oe`=0 and the outputs low. While the clocks run, this happens at the next frame boundary. Once valid codes return, the clocks restart one cycle later and `cfg_err` clears.
- R8: While `master_en`=0, `clk_oe`, `bclk_o` and `fclk_o` are 0 and the counters hold. When `master_en` returns to 1, the frame continues from where it stopped.
- R9: The fastest setting (H=1, frame code 1) gives a frame of 64 master cycles. That is 384 kHz from a 24.576 MHz master clock.
- R10: Whenever the clocks are running, `fclk_o` changes only in the cycle in which `bclk_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: generate clocks; 0: slave, outputs idle |
| tdm_mode | input | 1 | 0: I2S two-phase frame clock; 1: TDM sync pulse |
| rate_code | input | 4 | Half-ratio code H; bit clock = clk / (2·H) |
| frame_code | input | 4 | Frame length in units of 32 bit clocks; 0 means 512 |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock / frame sync |
| clk_oe | output | 1 | Drive enable for the clock pins |
| cfg_err | output | 1 | Unsupported code seen; clocks stopped |

## Verification
The bench builds the block with its default parameters: a 4-bit half-ratio field with a ceiling of 7, a 4-bit frame field and units of 32 bit clocks. With these, every supported ratio and every frame length up to 512 bit clocks can be reached, and the longest frame lasts 7168 cycles. Directed scenarios measure bit and frame periods, duty and frame clock shape in both framing modes. They move the configuration mid-frame to observe the boundary hand-over, pause in slave mode at a known offset to show that the counters hold, and drive both kinds of unsupported code.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int unsigned DEF_RATE_W    = 4;
    localparam int unsigned DEF_FRAME_W   = 4;
    localparam int unsigned DEF_UNIT_LOG2 = 5;
    localparam int unsigned DEF_HALF_MAX  = 7;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_TDM = 1'b1
    } fmt_e;

    function automatic logic half_ok(int unsigned h, int unsigned hmax);
        return (h >= 1) && (h <= hmax);
    endfunction

    function automatic logic frame_ok(int unsigned c);
        return (c == 0) || ((c & (c - 1)) == 0);
    endfunction

    function automatic logic cfg_ok(int unsigned h, int unsigned c,
                                    int unsigned hmax);
        return half_ok(h, hmax) && frame_ok(c);
    endfunction

    function automatic int unsigned frame_bits(int unsigned c, int unsigned fw,
                                               int unsigned ul);
        return (c == 0) ? (1 << (ul + fw)) : (c << ul);
    endfunction

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
    import aclk_pkg::*;
#(
    parameter int unsigned RATE_W    = DEF_RATE_W,
    parameter int unsigned FRAME_W   = DEF_FRAME_W,
    parameter int unsigned UNIT_LOG2 = DEF_UNIT_LOG2,
    parameter int unsigned HALF_MAX  = DEF_HALF_MAX,
    parameter int unsigned LEN_W     = UNIT_LOG2 + FRAME_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               master_en,
    input  logic               tdm_mode,
    input  logic [RATE_W-1:0]  rate_code,
    input  logic [FRAME_W-1:0] frame_code,
    input  logic               boundary,
    output logic               running,
    output logic [RATE_W-1:0]  act_half,
    output logic [LEN_W-1:0]   act_len,
    output fmt_e               act_fmt,
    output logic               cfg_err
);

    logic load_slot;
    logic codes_ok;

    assign load_slot = master_en && (!running || boundary);
    assign codes_ok  = cfg_ok(int'(rate_code), int'(frame_code), HALF_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            cfg_err  <= 1'b0;
            act_half <= RATE_W'(1);
            act_len  <= LEN_W'(1 << UNIT_LOG2);
            act_fmt  <= FMT_I2S;
        end else if (load_slot) begin
            if (codes_ok) begin
                running  <= 1'b1;
                cfg_err  <= 1'b0;
                act_half <= rate_code;
                act_len  <= LEN_W'(frame_bits(int'(frame_code), FRAME_W, UNIT_LOG2));
                act_fmt  <= tdm_mode ? FMT_TDM : FMT_I2S;
            end else begin
                running  <= 1'b0;
                cfg_err  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aclk_bitdiv.sv
module aclk_bitdiv #(
    parameter int unsigned RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] half,
    output logic              lvl,
    output logic              bit_end
);

    logic [RATE_W-1:0] div_cnt;
    logic              half_done;

    assign half_done = (div_cnt == half - RATE_W'(1));
    assign bit_end   = en && lvl && half_done;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_cnt <= '0;
            lvl     <= 1'b0;
        end else if (en) begin
            if (half_done) begin
                div_cnt <= '0;
                lvl     <= ~lvl;
            end else begin
                div_cnt <= div_cnt + RATE_W'(1);
            end
        end
    end

endmodule

// File: rtl/aclk_frame.sv
module aclk_frame
    import aclk_pkg::*;
#(
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_end,
    input  logic [LEN_W-1:0] len,
    input  fmt_e             fmt,
    output logic             boundary,
    output logic             fs_lvl
);

    logic [LEN_W-1:0] bit_cnt;
    logic             last_bit;

    assign last_bit = (bit_cnt == len - LEN_W'(1));
    assign boundary = bit_end && last_bit;

    always_comb begin
        if (fmt == FMT_TDM)
            fs_lvl = (bit_cnt == '0);
        else
            fs_lvl = (bit_cnt >= (len >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            bit_cnt <= '0;
        else if (bit_end)
            bit_cnt <= last_bit ? '0 : bit_cnt + LEN_W'(1);
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import aclk_pkg::*;
#(
    parameter int unsigned RATE_W    = DEF_RATE_W,
    parameter int unsigned FRAME_W   = DEF_FRAME_W,
    parameter int unsigned UNIT_LOG2 = DEF_UNIT_LOG2,
    parameter int unsigned HALF_MAX  = DEF_HALF_MAX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               master_en,
    input  logic               tdm_mode,
    input  logic [RATE_W-1:0]  rate_code,
    input  logic [FRAME_W-1:0] frame_code,
    output logic               bclk_o,
    output logic               fclk_o,
    output logic               clk_oe,
    output logic               cfg_err
);

    localparam int unsigned LEN_W = UNIT_LOG2 + FRAME_W + 1;

    logic              running;
    logic [RATE_W-1:0] act_half;
    logic [LEN_W-1:0]  act_len;
    fmt_e              act_fmt;
    logic              boundary;
    logic              bit_lvl;
    logic              bit_end;
    logic              fs_lvl;
    logic              gen_en;

    assign gen_en = running && master_en;

    aclk_ctrl #(
        .RATE_W   (RATE_W),
        .FRAME_W  (FRAME_W),
        .UNIT_LOG2(UNIT_LOG2),
        .HALF_MAX (HALF_MAX),
        .LEN_W    (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .master_en (master_en),
        .tdm_mode  (tdm_mode),
        .rate_code (rate_code),
        .frame_code(frame_code),
        .boundary  (boundary),
        .running   (running),
        .act_half  (act_half),
        .act_len   (act_len),
        .act_fmt   (act_fmt),
        .cfg_err   (cfg_err)
    );

    aclk_bitdiv #(
        .RATE_W(RATE_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (!running),
        .en     (gen_en),
        .half   (act_half),
        .lvl    (bit_lvl),
        .bit_end(bit_end)
    );

    aclk_frame #(
        .LEN_W(LEN_W)
    ) u_frm (
        .clk     (clk),
        .rst     (rst),
        .clr     (!running),
        .bit_end (bit_end),
        .len     (act_len),
        .fmt     (act_fmt),
        .boundary(boundary),
        .fs_lvl  (fs_lvl)
    );

    assign clk_oe = gen_en;
    assign bclk_o = gen_en && bit_lvl;
    assign fclk_o = gen_en && fs_lvl;

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker
    import aclk_pkg::*;
#(
    parameter int unsigned RATE_W   = DEF_RATE_W,
    parameter int unsigned FRAME_W  = DEF_FRAME_W,
    parameter int unsigned HALF_MAX = DEF_HALF_MAX
) (
    input logic               clk,
    input logic               rst,
    input logic               master_en,
    input logic [RATE_W-1:0]  rate_code,
    input logic [FRAME_W-1:0] frame_code,
    input logic               bclk_o,
    input logic               fclk_o,
    input logic               clk_oe,
    input logic               cfg_err
);

    assert_err_stops_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !clk_oe && !bclk_o && !fclk_o);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |->
            !$past(cfg_ok(int'(rate_code), int'(frame_code), HALF_MAX)));

    assert_slave_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> !clk_oe && !bclk_o && !fclk_o);

    assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
        !clk_oe |-> !bclk_o && !fclk_o);

    assert_fs_align_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_oe && $past(clk_oe) && (fclk_o != $past(fclk_o))) |-> $fell(bclk_o));

endmodule

bind audio_clkgen aclk_checker #(
    .RATE_W  (RATE_W),
    .FRAME_W (FRAME_W),
    .HALF_MAX(HALF_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .master_en (master_en),
    .rate_code (rate_code),
    .frame_code(frame_code),
    .bclk_o    (bclk_o),
    .fclk_o    (fclk_o),
    .clk_oe    (clk_oe),
    .cfg_err   (cfg_err)
);

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_en = 1'b1;
    logic       tdm_mode = 1'b0;
    logic [3:0] rate_code = 4'd1;
    logic [3:0] frame_code = 4'd1;
    logic       bclk_o, fclk_o, clk_oe, cfg_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    audio_clkgen u0 (
        .clk(clk), .rst(rst), .master_en(master_en), .tdm_mode(tdm_mode),
        .rate_code(rate_code), .frame_code(frame_code),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe(clk_oe), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gap_rise_f(output int n);
        logic prev;
        prev = fclk_o;
        n = 0;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (fclk_o && !prev) break;
            prev = fclk_o;
        end
    endtask

    task automatic gap_rise_b(output int n);
        logic prev;
        prev = bclk_o;
        n = 0;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (bclk_o && !prev) break;
            prev = bclk_o;
        end
    endtask

    task automatic high_len_f(output int n);
        int d;
        gap_rise_f(d);
        n = 0;
        while (fclk_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic high_len_b(output int n);
        int d;
        gap_rise_b(d);
        n = 0;
        while (bclk_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic apply(input int h, input int c, input logic tdm);
        int d;
        @(negedge clk);
        rate_code = 4'(h);
        frame_code = 4'(c);
        tdm_mode = tdm;
        gap_rise_f(d);
        gap_rise_f(d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 oe in reset", clk_oe, 0);
        check("R1 bclk in reset", bclk_o, 0);
        check("R1 fclk in reset", fclk_o, 0);
        check("R1 err in reset", cfg_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe after first load", clk_oe, 1);
        check("R1 err after first load", cfg_err, 0);
    endtask

    task automatic t_bitclk(input int h);
        int n;
        apply(h, 1, 1'b0);
        gap_rise_b(n);
        gap_rise_b(n);
        check($sformatf("R2 bclk period H=%0d", h), n, 2 * h);
        high_len_b(n);
        check($sformatf("R2 bclk high H=%0d", h), n, h);
    endtask

    task automatic t_frame(input int h, input int c, input logic tdm, input string req);
        int n, bits;
        bits = (c == 0) ? 512 : 32 * c;
        apply(h, c, tdm);
        gap_rise_f(n);
        check($sformatf("%s frame period H=%0d C=%0d", req, h, c), n, 2 * h * bits);
        high_len_f(n);
        if (tdm)
            check($sformatf("R5 sync width H=%0d C=%0d", h, c), n, 2 * h);
        else
            check($sformatf("R4 word select high H=%0d C=%0d", h, c), n, h * bits);
    endtask

    task automatic t_boundary();
        int n;
        apply(2, 1, 1'b1);
        n = 0;
        begin
            logic prev;
            prev = fclk_o;
            while (n < 20000) begin
                @(negedge clk);
                n++;
                if (n == 10) rate_code = 4'd3;
                if (fclk_o && !prev) break;
                prev = fclk_o;
            end
        end
        check("R6 frame in progress keeps old ratio", n, 128);
        gap_rise_f(n);
        check("R6 next frame uses new ratio", n, 192);
    endtask

    task automatic t_error(input int h, input int c, input string tag);
        int n;
        apply(2, 1, 1'b1);
        @(negedge clk);
        rate_code = 4'(h);
        frame_code = 4'(c);
        @(negedge clk);
        @(negedge clk);
        check($sformatf("R7 %s still running mid-frame", tag), clk_oe, 1);
        check($sformatf("R7 %s no error before boundary", tag), cfg_err, 0);
        n = 0;
        while (clk_oe && n < 400) begin
            @(negedge clk);
            n++;
        end
        check($sformatf("R7 %s error flag", tag), cfg_err, 1);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bclk_o || fclk_o || clk_oe) n++;
        end
        check($sformatf("R7 %s clocks stay stopped", tag), n, 0);
        rate_code = 4'd2;
        frame_code = 4'd1;
        @(negedge clk);
        check($sformatf("R7 %s error clears", tag), cfg_err, 0);
        check($sformatf("R7 %s clocks restart", tag), clk_oe, 1);
    endtask

    task automatic t_slave();
        int n, act;
        apply(2, 1, 1'b1);
        for (int i = 0; i < 40; i++) @(negedge clk);
        master_en = 1'b0;
        act = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bclk_o || fclk_o || clk_oe) act++;
        end
        check("R8 slave outputs idle", act, 0);
        master_en = 1'b1;
        gap_rise_f(n);
        check("R8 counters held through slave", n, 128 - 40);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        t_reset();
        t_bitclk(1);
        t_bitclk(4);
        t_bitclk(7);
        t_frame(1, 1, 1'b0, "R9");
        t_frame(2, 2, 1'b0, "R3");
        t_frame(3, 4, 1'b1, "R3");
        t_frame(1, 8, 1'b1, "R3");
        t_frame(1, 0, 1'b0, "R3");
        t_frame(7, 0, 1'b1, "R3");
        t_frame(1, 1, 1'b1, "R9");
        t_boundary();
        t_error(0, 1, "rate 0");
        t_error(9, 1, "rate 9");
        t_error(2, 3, "frame 3");
        t_slave();
        apply(1, 2, 1'b0);
        gap_rise_f(n);
        check("R10 steady frame after tests", n, 128);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule